// File: doc/BRIEF.md
# Oversampled Receive Bit Sampler

This block recovers bit timing from a serial receive line that a fast local clock oversamples. The line is brought into the clock domain through a short synchronizer chain. Every transition found on the synchronized level restarts a bit-period counter. A one-cycle strobe is then raised at a programmable phase offset behind that transition, and the level captured at the strobe is presented as the received bit. When no transition arrives, the counter keeps running at the bit period, so a strobe still follows once per period.

Two recovery variants are available. The first realigns on both transitions; the second realigns on rising transitions only. A bypass mode samples the line on rising edges of an external receive clock and ignores the internal counter. The configuration inputs are registered once, and those registers reset to zero.

The output side is a valid-only stream. A serial line cannot be stalled, so the block offers no back-pressure. The consumer must take `bit_out` in every cycle in which `bit_valid` is high. `bit_out` holds its value between strobes.

Top module: `rx_sample_recover`

## Requirements
- R1: While `rst_n` is low, `bit_valid` and `bit_out` are 0 and every registered configuration bit is 0.
- R2: In internal mode with `cfg_realign_sel`=0, take the clock edge at which a new `rx_data` level is first captured (edge 0). `bit_valid` is then high for the one cycle that follows edge 3+T, where T is the effective phase offset in clock cycles.
- R3: With no transitions on `rx_data`, consecutive internal strobes are exactly P cycles apart. P is BIT_PERIOD (20) when `cfg_double_step`=0 and 2×BIT_PERIOD (40) when `cfg_double_step`=1.
- R4: T equals `cfg_phase` when `cfg_double_step`=0 and 2×`cfg_phase` when `cfg_double_step`=1.
- R5: `cfg_phase` values 20 to 31 act as 19.
- R6: With `cfg_realign_sel`=0, a falling transition also restarts the counter, so the strobe timing of R2 applies to it.
- R7: With `cfg_realign_sel`=1, only rising transitions restart the counter. After a falling transition, the next strobe keeps the spacing P from the previous strobe.
- R8: With `cfg_ext_clk_sel`=1, a rising edge of `rx_ext_clk` first captured at edge 0 raises `bit_valid` in the cycle after edge 2. A falling edge of `rx_ext_clk` raises no strobe.
- R9: With `cfg_ext_clk_sel`=1, transitions on `rx_data` with `rx_ext_clk` idle raise no strobe.
- R10: At each strobe, `bit_out` equals the synchronized `rx_data` level, and it holds that value until the next strobe.
- R11: `bit_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 1 | Asynchronous serial receive line |
| rx_ext_clk | input | 1 | Asynchronous external receive clock |
| cfg_ext_clk_sel | input | 1 | 1: sample on external clock edges |
| cfg_realign_sel | input | 1 | 0: realign on both transitions, 1: rising only |
| cfg_double_step | input | 1 | 1: each phase step is two clock cycles |
| cfg_phase | input | 5 | Sample-point offset in steps, 0 to 19 |
| bit_out | output | 1 | Sampled receive bit |
| bit_valid | output | 1 | One-cycle strobe marking a new `bit_out` |

## Verification
A wrong counter value or a missed realignment shows up as a strobe that arrives early or late relative to the injected transition. That error is visible at the first strobe after the transition, which comes within 3+T cycles. A wrong wrap value only shows at the second strobe, as a gap that differs from P. A wrong phase clamp or step scale shifts the strobe by a fixed number of cycles for the affected settings, and a sweep over all 32 codes in both step modes exposes it. A wrong mode mux shows within a few cycles, either as strobes during a quiet external clock or as a missing strobe three cycles after an external rising edge.

// File: rtl/rxsr_pkg.sv
package rxsr_pkg;
  localparam int PHASE_W = 5;

  typedef struct packed {
    logic               ext_sel;
    logic               rise_only;
    logic               dbl;
    logic [PHASE_W-1:0] phase;
  } rxsr_cfg_t;
endpackage

// File: rtl/rxsr_sync.sv
module rxsr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxsr_edge.sv
module rxsr_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= lvl;

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/rxsr_phase.sv
module rxsr_phase #(
  parameter int BIT_PERIOD = 20,
  parameter int PHASE_W    = 5,
  parameter int PHASE_MAX  = 19,
  parameter int CNT_W      = $clog2(2*BIT_PERIOD+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               realign,
  input  logic               dbl,
  input  logic [PHASE_W-1:0] phase,
  output logic               hit,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   target
);
  localparam logic [CNT_W-1:0] LAST_1 = CNT_W'(BIT_PERIOD - 1);
  localparam logic [CNT_W-1:0] LAST_2 = CNT_W'(2*BIT_PERIOD - 1);
  localparam logic [PHASE_W-1:0] PMAX = PHASE_W'(PHASE_MAX);

  logic [CNT_W-1:0]   last;
  logic [PHASE_W-1:0] phase_eff;

  always_comb begin
    last      = dbl ? LAST_2 : LAST_1;
    phase_eff = (phase > PMAX) ? PMAX : phase;
    target    = dbl ? (CNT_W'(phase_eff) << 1) : CNT_W'(phase_eff);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           cnt <= '0;
    else if (realign)     cnt <= '0;
    else if (cnt >= last) cnt <= '0;
    else                  cnt <= cnt + 1'b1;

  assign hit = (cnt == target) && !realign;
endmodule

// File: rtl/rx_sample_recover.sv
module rx_sample_recover #(
  parameter int BIT_PERIOD  = 20,
  parameter int PHASE_MAX   = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_data,
  input  logic       rx_ext_clk,
  input  logic       cfg_ext_clk_sel,
  input  logic       cfg_realign_sel,
  input  logic       cfg_double_step,
  input  logic [4:0] cfg_phase,
  output logic       bit_out,
  output logic       bit_valid
);
  import rxsr_pkg::*;

  localparam int CNT_W = $clog2(2*BIT_PERIOD+1);
  localparam int LANES = 2;
  localparam int L_DAT = 0;
  localparam int L_EXT = 1;

  rxsr_cfg_t cfg_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= '{ext_sel: cfg_ext_clk_sel, rise_only: cfg_realign_sel,
                          dbl: cfg_double_step, phase: cfg_phase};

  logic [LANES-1:0] lvl, rise, fall;

  rxsr_sync #(.W(LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({rx_ext_clk, rx_data}), .q(lvl));

  rxsr_edge #(.W(LANES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall));

  logic realign, ext_rise, hit;
  logic [CNT_W-1:0] cnt, target;

  assign realign  = rise[L_DAT] | (fall[L_DAT] & ~cfg_q.rise_only);
  assign ext_rise = rise[L_EXT];

  rxsr_phase #(.BIT_PERIOD(BIT_PERIOD), .PHASE_W(PHASE_W),
               .PHASE_MAX(PHASE_MAX), .CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .realign(realign), .dbl(cfg_q.dbl),
    .phase(cfg_q.phase), .hit(hit), .cnt(cnt), .target(target));

  logic strobe;
  assign strobe = cfg_q.ext_sel ? ext_rise : hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
    end else begin
      bit_valid <= strobe;
      if (strobe) bit_out <= lvl[L_DAT];
    end
endmodule

// File: rtl/rxsr_chk.sv
module rxsr_chk #(
  parameter int BIT_PERIOD = 20,
  parameter int PHASE_MAX  = 19,
  parameter int CNT_W      = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic             ext_mode,
  input logic             ext_rise,
  input logic             realign,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] target
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !bit_valid);

  // R11
  no_back2back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  // R8
  ext_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && $past(ext_mode) && bit_valid) |-> $past(ext_rise));

  // R2
  realign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (cnt == '0));

  // R5
  target_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    target <= CNT_W'(2*PHASE_MAX));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(2*BIT_PERIOD));
endmodule

bind rx_sample_recover rxsr_chk #(
  .BIT_PERIOD(BIT_PERIOD), .PHASE_MAX(PHASE_MAX), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .ext_mode(cfg_q.ext_sel),
  .ext_rise(ext_rise), .realign(realign), .cnt(cnt), .target(target)
);

// File: tb/rx_sample_recover_test.sv
module rx_sample_recover_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_data = 1'b0, rx_ext_clk = 1'b0;
  logic cfg_ext_clk_sel = 1'b0, cfg_realign_sel = 1'b0, cfg_double_step = 1'b0;
  logic [4:0] cfg_phase = '0;
  logic bit_out, bit_valid;

  int errs = 0, checks = 0;

  always #4ns clk = ~clk;

  rx_sample_recover uut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ext_clk(rx_ext_clk),
    .cfg_ext_clk_sel(cfg_ext_clk_sel), .cfg_realign_sel(cfg_realign_sel),
    .cfg_double_step(cfg_double_step), .cfg_phase(cfg_phase),
    .bit_out(bit_out), .bit_valid(bit_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // Counts negedges until bit_valid is seen (or limit).
  task automatic wait_valid(input int limit, output int n);
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (bit_valid || n >= limit) break;
    end
  endtask

  task automatic count_valid(input int cycles, input bit toggle, output int v, output int dbl);
    bit last = 0;
    v = 0; dbl = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (toggle && (i % 7 == 3)) rx_data = ~rx_data;
      if (bit_valid) begin v++; if (last) dbl++; end
      last = bit_valid;
    end
  endtask

  task automatic settle(input int p);
    int n;
    wait_valid(3*p, n);
    wait_valid(3*p, n);
  endtask

  initial begin
    #(8ns * 150000);
    checks++; errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n, v, d, p, t;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    chk(bit_valid == 1'b0, "R1 bit_valid in reset", int'(bit_valid), 0);
    chk(bit_out == 1'b0, "R1 bit_out in reset", int'(bit_out), 0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R10: sweep every phase code in both step modes
    for (int dm = 0; dm < 2; dm++) begin
      for (int ph = 0; ph < 32; ph++) begin
        cfg_double_step = dm[0];
        cfg_phase = ph[4:0];
        p = dm ? 40 : 20;
        t = (ph > 19 ? 19 : ph) * (dm ? 2 : 1);
        settle(p);
        rx_data = ~rx_data;
        wait_valid(3*p, n);
        chk(n == 4 + t, ph > 19 ? "R5 clamped strobe delay" : "R2 R4 strobe delay", n, 4 + t);
        chk(bit_out == rx_data, "R10 bit at strobe", int'(bit_out), int'(rx_data));
        wait_valid(3*p, n);
        chk(n == p, "R3 free-run spacing", n, p);
        chk(bit_out == rx_data, "R10 bit held", int'(bit_out), int'(rx_data));
      end
    end

    // R11: steady stream with transitions, no consecutive strobes
    cfg_double_step = 1'b0; cfg_phase = 5'd5;
    count_valid(400, 1'b1, v, d);
    chk(d == 0, "R11 back-to-back strobes", d, 0);

    // R6: falling edge realigns in variant 0
    rx_data = 1'b1; settle(20);
    rx_data = 1'b0;
    wait_valid(60, n);
    chk(n == 9, "R6 falling realign", n, 9);

    // R7: variant 1 ignores falling, realigns on rising
    cfg_realign_sel = 1'b1;
    rx_data = 1'b1; settle(20);
    rx_data = 1'b0;
    wait_valid(60, n);
    chk(n == 20, "R7 falling ignored", n, 20);
    chk(bit_out == 1'b0, "R10 bit after falling", int'(bit_out), 0);
    rx_data = 1'b1;
    wait_valid(60, n);
    chk(n == 9, "R7 rising realign", n, 9);
    cfg_realign_sel = 1'b0;

    // R9: external mode, data activity with idle external clock
    cfg_ext_clk_sel = 1'b1;
    repeat (10) @(negedge clk);
    count_valid(150, 1'b1, v, d);
    chk(v == 0, "R9 no strobe without ext clock", v, 0);

    // R8 R10: external clock edges
    for (int k = 0; k < 8; k++) begin
      rx_data = k[0] ^ k[2];
      repeat (5) @(negedge clk);
      rx_ext_clk = 1'b1;
      wait_valid(20, n);
      chk(n == 3, "R8 ext strobe delay", n, 3);
      chk(bit_out == rx_data, "R10 ext bit", int'(bit_out), int'(rx_data));
      repeat (4) @(negedge clk);
      rx_ext_clk = 1'b0;
      count_valid(8, 1'b0, v, d);
      chk(v == 0, "R8 no strobe on falling ext edge", v, 0);
    end

    finish_run();
  end
endmodule